// File: doc/BRIEF.md
# Transmit De-emphasis FIR Serializer

This block is the digital front of a serial transmit equalizer. Once per word slot it takes a parallel word and turns it into a stream of one bit per unit interval (UI), lowest bit first. The block runs on the UI-rate clock. The serializer sits inside the emphasis stage, so the delayed-bit tap also reaches across word boundaries. For every UI that carries a bit, the block issues a registered signed amplitude code for a downstream current-steering DAC.

The code is the main weight times the polarity of the current bit, minus the post weight times the polarity of the bit before it. A bit value of 1 counts as +1 and a bit value of 0 counts as -1. A change of level therefore gets the boosted magnitude, main plus post. A repeated level gets the reduced magnitude, main minus post. The post weight comes from the main weight through a selectable ratio. A bypass input removes it altogether. An extra output flags each symbol as a transition or a repeat.

Top module: `de_emph_serializer`

## Requirements
- R1: Reset is synchronous and active low. During reset and until the first accepted word produces output, amp_out is 0 and amp_valid and amp_trans are 0. The remembered previous bit starts at 0, which counts as -1.
- R2: A word accepted at clock edge k produces its bit 0 on the outputs after edge k+1 and its bit 1 after edge k+2. amp_valid is 1 for both symbols.
- R3: When the current bit differs from the previous bit, |amp_out| equals C0+C1. amp_out is positive for bit value 1 and negative for bit value 0.
- R4: When the current bit equals the previous bit, |amp_out| equals C0-C1, with the same sign rule as R3.
- R5: C1 is floor(C0*ratio), where C0 = main_wt. ratio_sel selects the ratio: 0 gives 1/3, 1 gives 1/2, 2 gives 2/3 and 3 gives 1.
- R6: When bypass is 1, C1 is 0 and amp_out is +C0 or -C0 whatever the history.
- R7: The first bit of a word is compared with the last bit of the previously accepted word, including across idle UIs.
- R8: word_valid is ignored while bits of an accepted word remain to be sent, that is, in the cycle right after a word is accepted.
- R9: In a UI without a bit, amp_out is 0, amp_valid and amp_trans are 0, and the previous bit is kept.
- R10: amp_trans is 1 exactly when a valid symbol differs from its previous bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UI-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 2 | Parallel word, bit 0 is sent first |
| word_valid | input | 1 | word_in is offered this cycle |
| main_wt | input | 6 | Unsigned main-cursor weight C0 |
| ratio_sel | input | 2 | De-emphasis ratio select (0: 1/3, 1: 1/2, 2: 2/3, 3: 1) |
| bypass | input | 1 | Forces the post-cursor weight to 0 |
| amp_out | output | 8 | Signed two's-complement amplitude code |
| amp_valid | output | 1 | amp_out carries a symbol |
| amp_trans | output | 1 | Symbol is a transition |

## Verification
Two things can happen in the same cycle. The first bit of a new word is weighed against the last bit of the previous word, and in that same cycle the serializer may be loading the next word or refusing an early word_valid. The bench provokes this by offering words on every allowed slot. It also raises word_valid one cycle too early with a different word. The bench checks the first symbol of each word against a model that tracks the previous bit on its own. It then confirms that the refused word leaves no trace in the symbols that follow.

// File: rtl/de_emph_pkg.sv
// Shared types for the de-emphasis serializer.
package de_emph_pkg;

    // Ratio of post weight to main weight.
    typedef enum logic [1:0] {
        RATIO_THIRD      = 2'd0,
        RATIO_HALF       = 2'd1,
        RATIO_TWO_THIRDS = 2'd2,
        RATIO_FULL       = 2'd3
    } ratio_e;

endpackage

// File: rtl/de_emph_ser_stage.sv
// Parallel-to-serial stage. Loads a word when no bits are pending and
// emits one bit per clock, lowest bit first.
// Assumes: words are offered at most once per WORD_W cycles; any offer
// made while bits are pending is dropped.
module de_emph_ser_stage #(
    parameter int WORD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    output logic              bit_q,
    output logic              bit_vld
);
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;

    // Load a new word or shift out the next pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            left_q  <= '0;
            bit_q   <= 1'b0;
            bit_vld <= 1'b0;
        end else if (left_q != '0) begin
            bit_q   <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            left_q  <= left_q - 1'b1;
            bit_vld <= 1'b1;
        end else if (word_valid) begin
            bit_q   <= word_in[0];
            shreg_q <= word_in >> 1;
            left_q  <= CNT_W'(WORD_W - 1);
            bit_vld <= 1'b1;
        end else begin
            bit_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/de_emph_tap_weights.sv
// Works out the post-cursor weight from the main weight and the ratio
// select, rounding down. Bypass forces it to zero.
// Assumes: the result never exceeds the main weight.
module de_emph_tap_weights
    import de_emph_pkg::*;
#(
    parameter int C_W = 6
) (
    input  logic [C_W-1:0] main_wt,
    input  ratio_e         ratio,
    input  logic           bypass,
    output logic [C_W-1:0] post_wt
);
    localparam int P_W = C_W + 1;

    logic [P_W-1:0] ext_wt;
    logic [P_W-1:0] scaled;

    assign ext_wt = {1'b0, main_wt};

    // Pick the scaled weight for the selected ratio.
    always_comb begin
        unique case (ratio)
            RATIO_THIRD:      scaled = ext_wt / P_W'(3);
            RATIO_HALF:       scaled = ext_wt >> 1;
            RATIO_TWO_THIRDS: scaled = (ext_wt << 1) / P_W'(3);
            default:          scaled = ext_wt;
        endcase
        post_wt = bypass ? '0 : scaled[C_W-1:0];
    end
endmodule

// File: rtl/de_emph_fir_stage.sv
// One-post-tap FIR. Weighs the current bit against the remembered
// previous bit and registers a signed amplitude code each UI.
// Assumes: post_wt <= main_wt and A_W > C_W + 1.
module de_emph_fir_stage #(
    parameter int C_W = 6,
    parameter int A_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_q,
    input  logic                  bit_vld,
    input  logic [C_W-1:0]        main_wt,
    input  logic [C_W-1:0]        post_wt,
    output logic signed [A_W-1:0] amp_q,
    output logic                  vld_q,
    output logic                  trans_q
);
    localparam int M_W = C_W + 1;

    logic                  prev_q;
    logic                  trans;
    logic [M_W-1:0]        mag;
    logic signed [A_W-1:0] mag_ext;
    logic signed [A_W-1:0] amp_next;

    // Choose the boosted or reduced magnitude and apply the bit's sign.
    always_comb begin
        trans    = bit_q ^ prev_q;
        mag      = trans ? ({1'b0, main_wt} + {1'b0, post_wt})
                         : ({1'b0, main_wt} - {1'b0, post_wt});
        mag_ext  = {{(A_W-M_W){1'b0}}, mag};
        amp_next = bit_q ? mag_ext : (A_W'(0) - mag_ext);
    end

    // Register the symbol and move the history forward on valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            amp_q   <= '0;
            vld_q   <= 1'b0;
            trans_q <= 1'b0;
        end else if (bit_vld) begin
            prev_q  <= bit_q;
            amp_q   <= amp_next;
            vld_q   <= 1'b1;
            trans_q <= trans;
        end else begin
            amp_q   <= '0;
            vld_q   <= 1'b0;
            trans_q <= 1'b0;
        end
    end
endmodule

// File: rtl/de_emph_serializer.sv
// Top: a 2:1 serializer merged into a one-post-tap de-emphasis FIR.
// Assumes: the weight inputs are steady while a word is in flight.
module de_emph_serializer
    import de_emph_pkg::*;
#(
    parameter int C_W    = 6,
    parameter int A_W    = 8,
    parameter int WORD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    input  logic [C_W-1:0]    main_wt,
    input  logic [1:0]        ratio_sel,
    input  logic              bypass,
    output logic [A_W-1:0]    amp_out,
    output logic              amp_valid,
    output logic              amp_trans
);
    logic                  ser_bit;
    logic                  ser_vld;
    logic [C_W-1:0]        post_wt;
    logic signed [A_W-1:0] amp_s;

    de_emph_ser_stage #(.WORD_W(WORD_W)) ser_i (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_valid(word_valid),
        .bit_q(ser_bit), .bit_vld(ser_vld)
    );

    de_emph_tap_weights #(.C_W(C_W)) wt_i (
        .main_wt(main_wt), .ratio(ratio_e'(ratio_sel)), .bypass(bypass),
        .post_wt(post_wt)
    );

    de_emph_fir_stage #(.C_W(C_W), .A_W(A_W)) fir_i (
        .clk(clk), .rst_n(rst_n), .bit_q(ser_bit), .bit_vld(ser_vld),
        .main_wt(main_wt), .post_wt(post_wt),
        .amp_q(amp_s), .vld_q(amp_valid), .trans_q(amp_trans)
    );

    assign amp_out = amp_s;
endmodule

// File: rtl/de_emph_serializer_chk.sv
// Property checker for de_emph_serializer, attached by bind.
// Watches the ports only and keeps its own count of pending bits.
module de_emph_serializer_chk #(
    parameter int C_W    = 6,
    parameter int A_W    = 8,
    parameter int WORD_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word_in,
    input logic              word_valid,
    input logic [C_W-1:0]    main_wt,
    input logic [1:0]        ratio_sel,
    input logic              bypass,
    input logic [A_W-1:0]    amp_out,
    input logic              amp_valid,
    input logic              amp_trans
);
    int  pend;
    logic acc;
    logic [A_W-1:0] mag;

    assign acc = word_valid && (pend == 0);
    assign mag = amp_out[A_W-1] ? (A_W'(0) - amp_out) : amp_out;

    // Track the bits still owed by the last accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 0;
        else if (acc) pend <= WORD_W - 1;
        else if (pend != 0) pend <= pend - 1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_valid |-> (amp_out == '0) && !amp_trans);                       // R9
    AST_FIRST_BIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##2 amp_valid);                                             // R2
    AST_TRANS_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid && amp_trans |-> mag >= A_W'($past(main_wt)));            // R3
    AST_REPEAT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid && !amp_trans |-> mag <= A_W'($past(main_wt)));           // R4
    AST_BYPASS_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid && $past(bypass) |-> mag == A_W'($past(main_wt)));        // R6
endmodule

bind de_emph_serializer de_emph_serializer_chk #(
    .C_W(C_W), .A_W(A_W), .WORD_W(WORD_W)
) chk_i (.*);

// File: tb/de_emph_serializer_tb_top.sv
// Directed bench for de_emph_serializer, one task per scenario.
module de_emph_serializer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] word_in = '0;
    logic       word_valid = 1'b0;
    logic [5:0] main_wt = '0;
    logic [1:0] ratio_sel = '0;
    logic       bypass = 1'b0;
    logic [7:0] amp_out;
    logic       amp_valid;
    logic       amp_trans;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  ref_prev = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    de_emph_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_valid(word_valid),
        .main_wt(main_wt), .ratio_sel(ratio_sel), .bypass(bypass),
        .amp_out(amp_out), .amp_valid(amp_valid), .amp_trans(amp_trans)
    );

    function automatic int post_of();
        int c0 = int'(main_wt);
        if (bypass) return 0;
        case (ratio_sel)
            2'd0: return c0 / 3;
            2'd1: return c0 / 2;
            2'd2: return (2 * c0) / 3;
            default: return c0;
        endcase
    endfunction

    task automatic check_sym(input bit b, input string tag);
        int  c1 = post_of();
        bit  tr = (b != ref_prev);
        int  m  = tr ? int'(main_wt) + c1 : int'(main_wt) - c1;
        logic [7:0] exp_amp = b ? 8'(m) : 8'(-m);
        n_checks++;
        if (amp_out !== exp_amp || amp_valid !== 1'b1 || amp_trans !== tr) begin
            n_fail++;
            $display("FAIL %s: amp=%0d vld=%b tr=%b expected amp=%0d vld=1 tr=%b",
                     tag, $signed(amp_out), amp_valid, amp_trans, $signed(exp_amp), tr);
        end
        ref_prev = b;
    endtask

    task automatic check_idle(input string tag);
        n_checks++;
        if (amp_out !== 8'd0 || amp_valid !== 1'b0 || amp_trans !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: amp=%0d vld=%b tr=%b expected amp=0 vld=0 tr=0",
                     tag, $signed(amp_out), amp_valid, amp_trans);
        end
    endtask

    task automatic set_cfg(input logic [5:0] c0, input logic [1:0] r, input logic byp);
        @(negedge clk);
        main_wt = c0; ratio_sel = r; bypass = byp;
    endtask

    // Send one word and check both of its symbols.
    task automatic run_word(input logic [1:0] w, input string tag);
        @(negedge clk); word_valid = 1'b1; word_in = w;
        @(negedge clk); word_valid = 1'b0;
        @(negedge clk); check_sym(w[0], {tag, " bit0"});
        @(negedge clk); check_sym(w[1], {tag, " bit1"});
    endtask

    // R1: quiet outputs during and after reset; previous bit starts at -1.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk); check_idle("R1 after reset");
        main_wt = 6'd30; ratio_sel = 2'd0; bypass = 1'b0;
        run_word(2'b10, "R1 first word prev=-1");
    endtask

    // R3, R4, R5, R10: every ratio setting with both kinds of symbol.
    task automatic t_ratios();
        set_cfg(6'd30, 2'd0, 1'b0); run_word(2'b01, "R5 ratio 1/3 R3");
        run_word(2'b11, "R4 R10 repeat 1/3");
        set_cfg(6'd31, 2'd1, 1'b0); run_word(2'b10, "R5 ratio 1/2 R3");
        run_word(2'b00, "R4 ratio 1/2");
        set_cfg(6'd31, 2'd2, 1'b0); run_word(2'b01, "R5 ratio 2/3 R10");
        run_word(2'b11, "R4 ratio 2/3");
        set_cfg(6'd63, 2'd3, 1'b0); run_word(2'b10, "R5 ratio 1 R3");
        run_word(2'b00, "R4 ratio 1 zero");
    endtask

    // R6: bypass gives a flat +/-C0.
    task automatic t_bypass();
        set_cfg(6'd25, 2'd3, 1'b1); run_word(2'b01, "R6 bypass trans");
        run_word(2'b11, "R6 bypass repeat");
        set_cfg(6'd30, 2'd0, 1'b0);
    endtask

    // R2, R7: back-to-back words, the first bit is weighed against the previous word.
    task automatic t_back_to_back();
        @(negedge clk); word_valid = 1'b1; word_in = 2'b01;
        @(negedge clk); word_valid = 1'b0;
        @(negedge clk); word_valid = 1'b1; word_in = 2'b10; check_sym(1'b1, "R2 b2b w1 bit0");
        @(negedge clk); word_valid = 1'b0;                  check_sym(1'b0, "R2 b2b w1 bit1");
        @(negedge clk); check_sym(1'b0, "R7 b2b w2 bit0 across boundary");
        @(negedge clk); check_sym(1'b1, "R7 b2b w2 bit1");
    endtask

    // R8, R9: an early offer is dropped, then an idle UI, then the history holds.
    task automatic t_early_offer();
        @(negedge clk); word_valid = 1'b1; word_in = 2'b00;
        @(negedge clk); word_in = 2'b11;
        @(negedge clk); word_valid = 1'b0; check_sym(1'b0, "R8 kept bit0");
        @(negedge clk); check_sym(1'b0, "R8 kept bit1");
        @(negedge clk); check_idle("R8 R9 dropped word gives idle");
        repeat (3) @(negedge clk);
        check_idle("R9 idle gap");
        run_word(2'b10, "R7 R9 history after gap");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ratios();
        t_bypass();
        t_back_to_back();
        t_early_offer();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule